// File: doc/BRIEF.md
# Jet threshold and RoI encoder

This block sits after the cluster-sum adder trees of a jet trigger processor. For each of eight RoI slots it gets the 2x2, 3x3 and 4x4 cluster sums of the four candidate positions in that slot. It also gets a per-position local-maximum flag and a per-position overflow flag. Each slot's local maximum is tested against eight programmable thresholds. Every threshold has its own cluster-size selection, so one comparator serves each threshold.

Each slot gives one region-of-interest word. The word holds the passed-threshold bits, a saturate flag, the 2-bit position of the maximum and an odd-parity bit. The passed bits of all slots are also counted per threshold, which gives eight saturating jet multiplicities. A whole event goes in on one cycle with `ev_valid`, and its results appear on the next cycle with `out_valid`. Threshold levels and size selections are loaded through a single-cycle write port.

Top module: `jet_roi_enc`

## Requirements
- R1: RoI word layout with default parameters: bits [7:0] are passed flags for thresholds 0..7, bit 8 is the saturate flag, bits [10:9] are the location code and bit 11 is parity. The location code equals the index p of the set maximum flag within the slot: flag bit `cand_max[4*slot+p]`, with p=0..3 giving codes 00, 01, 10, 11.
- R2: Threshold k is passed by a slot whose maximum has a sum strictly greater than threshold level k. The sum is the one of the size chosen for k: size code 0 = 2x2, 1 = 3x3, 2 and 3 = 4x4.
- R3: A slot with no maximum flag set has passed bits, saturate flag and location code all zero, whatever its sums and overflow flags are.
- R4: If the overflow flag of the slot's maximum position is set, the slot passes all eight thresholds and its saturate flag is 1. An overflow flag on a non-maximum position has no effect.
- R5: Jet count k (`jet_cnt[3k+2:3k]`) is the number of slots whose word has passed bit k set. It is capped at 7 and does not wrap.
- R6: Bit 11 of every RoI word makes the number of ones in the 12-bit word odd.
- R7: Results of an event are presented one cycle after the `ev_valid` cycle, with `out_valid` high for exactly that cycle. `roi_word` and `jet_cnt` hold their values until the next event.
- R8: A configuration write that happens in the same cycle as `ev_valid` does not affect that event. It applies from the next event on.
- R9: After reset, `out_valid`, `roi_word` and `jet_cnt` are zero. All threshold levels are all-ones and all size codes are 0, so only overflowed maxima pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Threshold index being written |
| cfg_level | input | 10 | New threshold level |
| cfg_size | input | 2 | New cluster-size code |
| ev_valid | input | 1 | Event inputs valid this cycle |
| cand_sum2 | input | 320 | 2x2 sums, SW bits per (slot, position), index 4*slot+pos |
| cand_sum3 | input | 320 | 3x3 sums, same packing |
| cand_sum4 | input | 320 | 4x4 sums, same packing |
| cand_max | input | 32 | Local-maximum flag per (slot, position) |
| cand_ovf | input | 32 | Cluster overflow flag per (slot, position) |
| out_valid | output | 1 | Results of the previous event valid |
| roi_word | output | 96 | Eight 12-bit RoI words, slot s at bits [12s+11:12s] |
| jet_cnt | output | 24 | Eight 3-bit jet multiplicities |

## Verification
The assertions assume that at most one maximum flag is set per slot. Two neighbouring positions cannot both be local maxima, and the checker states this as an input property on every event. The stimulus keeps to it by giving each slot either no flag or exactly one. It also keeps every sum below the 10-bit ceiling, so that only the explicit overflow flag drives saturation. Configuration writes are issued between events, except in the one scenario that puts a write on the event cycle on purpose.

// File: rtl/jet_roi_pkg.sv
package jet_roi_pkg;
   // candidate positions per RoI slot (2x2 pattern) and code width
   localparam int NPOS = 4;
   localparam int LOCW = 2;

   typedef enum logic [1:0] {
      SZ_2X2  = 2'd0,
      SZ_3X3  = 2'd1,
      SZ_4X4  = 2'd2,
      SZ_4X4A = 2'd3
   } clus_size_e;
endpackage

// File: rtl/jet_roi_cfg.sv
module jet_roi_cfg #(
   parameter int NTHR = 8,
   parameter int SW   = 10,
   localparam int IW  = $clog2(NTHR)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IW-1:0]     idx,
   input  logic [SW-1:0]     level,
   input  logic [1:0]        size,
   output logic [NTHR*SW-1:0] lvl_q,
   output logic [NTHR*2-1:0]  sz_q
);
   for (genvar k = 0; k < NTHR; k++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl_q[k*SW +: SW] <= '1;
            sz_q[k*2 +: 2]    <= 2'd0;
         end else if (we && idx == IW'(k)) begin
            lvl_q[k*SW +: SW] <= level;
            sz_q[k*2 +: 2]    <= size;
         end
      end
   end
endmodule

// File: rtl/jet_slot_enc.sv
module jet_slot_enc
   import jet_roi_pkg::*;
#(
   parameter int NTHR       = 8,
   parameter int SW         = 10,
   parameter bit SHARED_CMP = 1'b1
) (
   input  logic [NPOS*SW-1:0] s2,
   input  logic [NPOS*SW-1:0] s3,
   input  logic [NPOS*SW-1:0] s4,
   input  logic [NPOS-1:0]    maxf,
   input  logic [NPOS-1:0]    ovf,
   input  logic [NTHR*SW-1:0] lvl,
   input  logic [NTHR*2-1:0]  sz,
   output logic [NTHR-1:0]    pass,
   output logic               sat,
   output logic [LOCW-1:0]    loc
);
   logic          hit;
   logic [SW-1:0] v2, v3, v4;

   always_comb begin
      hit = |maxf;
      loc = '0;
      for (int p = NPOS - 1; p >= 0; p--)
         if (maxf[p]) loc = LOCW'(p);
      v2  = s2[loc*SW +: SW];
      v3  = s3[loc*SW +: SW];
      v4  = s4[loc*SW +: SW];
      sat = hit & ovf[loc];
   end

   for (genvar k = 0; k < NTHR; k++) begin : g_thr
      clus_size_e    sel;
      logic [SW-1:0] ref_lvl;
      logic          over;
      assign sel     = clus_size_e'(sz[k*2 +: 2]);
      assign ref_lvl = lvl[k*SW +: SW];

      if (SHARED_CMP) begin : g_mux_first
         logic [SW-1:0] pick;
         always_comb begin
            unique case (sel)
               SZ_2X2:  pick = v2;
               SZ_3X3:  pick = v3;
               default: pick = v4;
            endcase
         end
         assign over = pick > ref_lvl;
      end else begin : g_cmp_first
         logic o2, o3, o4;
         assign o2 = v2 > ref_lvl;
         assign o3 = v3 > ref_lvl;
         assign o4 = v4 > ref_lvl;
         always_comb begin
            unique case (sel)
               SZ_2X2:  over = o2;
               SZ_3X3:  over = o3;
               default: over = o4;
            endcase
         end
      end

      assign pass[k] = hit & (sat | over);
   end
endmodule

// File: rtl/jet_mult_count.sv
module jet_mult_count #(
   parameter int NSLOT = 8,
   parameter int NTHR  = 8,
   parameter int CW    = 3
) (
   input  logic [NSLOT*NTHR-1:0] pass_all,
   output logic [NTHR*CW-1:0]    cnt
);
   localparam int CMAX = (1 << CW) - 1;

   for (genvar k = 0; k < NTHR; k++) begin : g_cnt
      always_comb begin
         int tally;
         tally = 0;
         for (int s = 0; s < NSLOT; s++)
            tally = tally + int'(pass_all[s*NTHR + k]);
         cnt[k*CW +: CW] = (tally > CMAX) ? CW'(CMAX) : CW'(tally);
      end
   end
endmodule

// File: rtl/jet_roi_enc.sv
module jet_roi_enc
   import jet_roi_pkg::*;
#(
   parameter int NSLOT      = 8,
   parameter int NTHR       = 8,
   parameter int SW         = 10,
   parameter int CW         = 3,
   parameter bit SHARED_CMP = 1'b1,
   localparam int IW        = $clog2(NTHR),
   localparam int WW        = NTHR + LOCW + 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [IW-1:0]            cfg_idx,
   input  logic [SW-1:0]            cfg_level,
   input  logic [1:0]               cfg_size,
   input  logic                     ev_valid,
   input  logic [NSLOT*NPOS*SW-1:0] cand_sum2,
   input  logic [NSLOT*NPOS*SW-1:0] cand_sum3,
   input  logic [NSLOT*NPOS*SW-1:0] cand_sum4,
   input  logic [NSLOT*NPOS-1:0]    cand_max,
   input  logic [NSLOT*NPOS-1:0]    cand_ovf,
   output logic                     out_valid,
   output logic [NSLOT*WW-1:0]      roi_word,
   output logic [NTHR*CW-1:0]       jet_cnt
);
   localparam int SLOT_SW = NPOS * SW;

   if (NTHR < 2)  begin : g_bad_nthr  $error("NTHR must be at least 2");  end
   if (NSLOT < 1) begin : g_bad_nslot $error("NSLOT must be at least 1"); end
   if (SW < 2)    begin : g_bad_sw    $error("SW must be at least 2");    end
   if (CW < 1)    begin : g_bad_cw    $error("CW must be at least 1");    end

   logic [NTHR*SW-1:0]    lvl_q;
   logic [NTHR*2-1:0]     sz_q;
   logic [NSLOT*NTHR-1:0] pass_all;
   logic [NSLOT*WW-1:0]   word_d;
   logic [NTHR*CW-1:0]    cnt_d;

   jet_roi_cfg #(.NTHR(NTHR), .SW(SW)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .idx   (cfg_idx),
      .level (cfg_level),
      .size  (cfg_size),
      .lvl_q (lvl_q),
      .sz_q  (sz_q)
   );

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      logic [NTHR-1:0]   pass;
      logic              sat;
      logic [LOCW-1:0]   loc;
      logic [WW-2:0]     body;

      jet_slot_enc #(.NTHR(NTHR), .SW(SW), .SHARED_CMP(SHARED_CMP)) u_enc (
         .s2   (cand_sum2[s*SLOT_SW +: SLOT_SW]),
         .s3   (cand_sum3[s*SLOT_SW +: SLOT_SW]),
         .s4   (cand_sum4[s*SLOT_SW +: SLOT_SW]),
         .maxf (cand_max[s*NPOS +: NPOS]),
         .ovf  (cand_ovf[s*NPOS +: NPOS]),
         .lvl  (lvl_q),
         .sz   (sz_q),
         .pass (pass),
         .sat  (sat),
         .loc  (loc)
      );

      assign body                   = {loc, sat, pass};
      assign word_d[s*WW +: WW]     = {~^body, body};
      assign pass_all[s*NTHR +: NTHR] = pass;
   end

   jet_mult_count #(.NSLOT(NSLOT), .NTHR(NTHR), .CW(CW)) u_cnt (
      .pass_all (pass_all),
      .cnt      (cnt_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         roi_word  <= '0;
         jet_cnt   <= '0;
      end else begin
         out_valid <= ev_valid;
         if (ev_valid) begin
            roi_word <= word_d;
            jet_cnt  <= cnt_d;
         end
      end
   end
endmodule

// File: rtl/jet_roi_enc_chk.sv
module jet_roi_enc_chk #(
   parameter int NSLOT = 8,
   parameter int NTHR  = 8,
   parameter int CW    = 3,
   localparam int NPOS = 4,
   localparam int WW   = NTHR + 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  ev_valid,
   input logic [NSLOT*NPOS-1:0] cand_max,
   input logic                  out_valid,
   input logic [NSLOT*WW-1:0]   roi_word,
   input logic [NTHR*CW-1:0]    jet_cnt
);
   // R7
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid |=> out_valid);

   // R7
   valid_only_after_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_valid |=> !out_valid);

   // R7
   hold_between_events_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_valid |=> ($stable(roi_word) && $stable(jet_cnt)));

   for (genvar s = 0; s < NSLOT; s++) begin : g_s
      // R1
      one_max_per_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ev_valid |-> $onehot0(cand_max[s*NPOS +: NPOS]));

      // R6
      odd_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (^roi_word[s*WW +: WW]) == 1'b1);

      // R3
      empty_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ev_valid && cand_max[s*NPOS +: NPOS] == '0) |=> roi_word[s*WW +: WW-1] == '0);
   end

   for (genvar k = 0; k < NTHR; k++) begin : g_k
      // R5
      count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ev_valid |=> int'(jet_cnt[k*CW +: CW]) <= $past($countones(cand_max)));
   end
endmodule

bind jet_roi_enc jet_roi_enc_chk #(.NSLOT(NSLOT), .NTHR(NTHR), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ev_valid  (ev_valid),
   .cand_max  (cand_max),
   .out_valid (out_valid),
   .roi_word  (roi_word),
   .jet_cnt   (jet_cnt)
);

// File: tb/jet_roi_enc_test.sv
module jet_roi_enc_test;
   localparam int NS = 8, NT = 8, SW = 10, CW = 3, NP = 4, WW = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [2:0] cfg_idx = '0;
   logic [SW-1:0] cfg_level = '0;
   logic [1:0] cfg_size = '0;
   logic ev_valid = 1'b0;
   logic [NS*NP*SW-1:0] cand_sum2 = '0, cand_sum3 = '0, cand_sum4 = '0;
   logic [NS*NP-1:0] cand_max = '0, cand_ovf = '0;
   logic out_valid;
   logic [NS*WW-1:0] roi_word;
   logic [NT*CW-1:0] jet_cnt;

   logic [SW-1:0] s2_a [NS][NP];
   logic [SW-1:0] s3_a [NS][NP];
   logic [SW-1:0] s4_a [NS][NP];
   logic          mx_a [NS][NP];
   logic          ov_a [NS][NP];
   logic [SW-1:0] thr_m [NT];
   logic [1:0]    sz_m [NT];

   int total = 0, bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   jet_roi_enc uut (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_stim();
      for (int s = 0; s < NS; s++)
         for (int p = 0; p < NP; p++) begin
            s2_a[s][p] = '0; s3_a[s][p] = '0; s4_a[s][p] = '0;
            mx_a[s][p] = 1'b0; ov_a[s][p] = 1'b0;
         end
   endtask

   task automatic pack();
      for (int s = 0; s < NS; s++)
         for (int p = 0; p < NP; p++) begin
            cand_sum2[(s*NP+p)*SW +: SW] = s2_a[s][p];
            cand_sum3[(s*NP+p)*SW +: SW] = s3_a[s][p];
            cand_sum4[(s*NP+p)*SW +: SW] = s4_a[s][p];
            cand_max[s*NP+p] = mx_a[s][p];
            cand_ovf[s*NP+p] = ov_a[s][p];
         end
   endtask

   function automatic logic [WW-1:0] exp_word(int s);
      logic [WW-1:0] w;
      logic [SW-1:0] v;
      int loc;
      w = '0;
      loc = -1;
      for (int p = NP - 1; p >= 0; p--) if (mx_a[s][p]) loc = p;
      if (loc >= 0) begin
         w[8] = ov_a[s][loc];
         w[10:9] = 2'(loc);
         for (int k = 0; k < NT; k++) begin
            v = (sz_m[k] == 2'd0) ? s2_a[s][loc] : (sz_m[k] == 2'd1) ? s3_a[s][loc] : s4_a[s][loc];
            w[k] = ov_a[s][loc] || (v > thr_m[k]);
         end
      end
      w[11] = ~^w[10:0];
      return w;
   endfunction

   function automatic int exp_cnt(int k);
      int n;
      logic [WW-1:0] w;
      n = 0;
      for (int s = 0; s < NS; s++) begin
         w = exp_word(s);
         n += int'(w[k]);
      end
      return (n > 7) ? 7 : n;
   endfunction

   task automatic cfg_write(input int k, input int lvl, input int sz);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 3'(k); cfg_level = SW'(lvl); cfg_size = 2'(sz);
      @(negedge clk);
      cfg_we = 1'b0;
      thr_m[k] = SW'(lvl); sz_m[k] = 2'(sz);
   endtask

   // fires one event (optionally with a concurrent config write) and checks it
   task automatic fire(input string req, input bit with_cfg = 1'b0,
                       input int ck = 0, input int cl = 0, input int cs = 0);
      @(negedge clk);
      pack();
      ev_valid = 1'b1;
      if (with_cfg) begin
         cfg_we = 1'b1; cfg_idx = 3'(ck); cfg_level = SW'(cl); cfg_size = 2'(cs);
      end
      @(negedge clk);
      ev_valid = 1'b0;
      cfg_we = 1'b0;
      chk(out_valid == 1'b1, {req, " R7 out_valid"}, int'(out_valid), 1);
      for (int s = 0; s < NS; s++)
         chk(roi_word[s*WW +: WW] == exp_word(s), {req, " word"},
             int'(roi_word[s*WW +: WW]), int'(exp_word(s)));
      for (int k = 0; k < NT; k++)
         chk(jet_cnt[k*CW +: CW] == 3'(exp_cnt(k)), {req, " R5 count"},
             int'(jet_cnt[k*CW +: CW]), exp_cnt(k));
      if (with_cfg) begin
         thr_m[ck] = SW'(cl); sz_m[ck] = 2'(cs);
      end
   endtask

   task automatic t_reset();
      for (int k = 0; k < NT; k++) begin thr_m[k] = '1; sz_m[k] = 2'd0; end
      clear_stim();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R9 out_valid", int'(out_valid), 0);
      chk(roi_word == '0, "R9 roi_word", int'(roi_word[31:0]), 0);
      chk(jet_cnt == '0, "R9 jet_cnt", int'(jet_cnt), 0);
      rst_n = 1'b1;
      // R9: default levels reject all non-overflow maxima
      for (int s = 0; s < NS; s++) begin
         mx_a[s][1] = 1'b1; s2_a[s][1] = 10'd1000;
      end
      fire("R9 default config");
   endtask

   task automatic t_mixed();
      for (int k = 0; k < NT; k++) cfg_write(k, 40 + 15*k, k % 3);
      clear_stim();
      for (int s = 0; s < NS; s++)
         for (int p = 0; p < NP; p++) begin
            s2_a[s][p] = SW'(s*20 + p*3 + 10);
            s3_a[s][p] = SW'(s*20 + p*3 + 35);
            s4_a[s][p] = SW'(s*20 + p*3 + 65);
         end
      for (int s = 0; s < 6; s++) mx_a[s][s % 4] = 1'b1;
      fire("R1 R2 R6 mixed");
   endtask

   task automatic t_no_max();
      clear_stim();
      for (int s = 0; s < NS; s++)
         for (int p = 0; p < NP; p++) begin
            s2_a[s][p] = 10'd900; s3_a[s][p] = 10'd900; s4_a[s][p] = 10'd900;
            ov_a[s][p] = (p == 2);
         end
      fire("R3 no maxima");
   endtask

   task automatic t_overflow();
      clear_stim();
      mx_a[2][1] = 1'b1; ov_a[2][1] = 1'b1;
      mx_a[4][3] = 1'b1; ov_a[4][0] = 1'b1;
      s2_a[4][3] = 10'd50; s3_a[4][3] = 10'd60; s4_a[4][3] = 10'd70;
      fire("R4 overflow");
   endtask

   task automatic t_saturate();
      cfg_write(0, 0, 0);
      clear_stim();
      for (int s = 0; s < NS; s++) begin
         mx_a[s][3] = 1'b1; s2_a[s][3] = 10'd5; s3_a[s][3] = 10'd5; s4_a[s][3] = 10'd5;
      end
      fire("R5 saturation");
      chk(jet_cnt[2:0] == 3'd7, "R5 cap at 7", int'(jet_cnt[2:0]), 7);
   endtask

   task automatic t_hold();
      logic [NS*WW-1:0] w0;
      logic [NT*CW-1:0] c0;
      w0 = roi_word; c0 = jet_cnt;
      clear_stim();
      pack();
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R7 idle out_valid", int'(out_valid), 0);
      chk(roi_word == w0, "R7 hold words", int'(roi_word[31:0]), int'(w0[31:0]));
      chk(jet_cnt == c0, "R7 hold counts", int'(jet_cnt), int'(c0));
   endtask

   task automatic t_cfg_same_cycle();
      clear_stim();
      for (int s = 0; s < NS; s++) begin
         mx_a[s][0] = 1'b1; s2_a[s][0] = 10'd300; s3_a[s][0] = 10'd300; s4_a[s][0] = 10'd300;
      end
      fire("R8 write on event cycle", 1'b1, 1, 1000, 2);
      fire("R8 next event");
      chk(jet_cnt[5:3] == 3'd0, "R8 new level applied", int'(jet_cnt[5:3]), 0);
   endtask

   task automatic t_size3();
      cfg_write(7, 100, 3);
      clear_stim();
      mx_a[0][2] = 1'b1; s2_a[0][2] = 10'd0; s3_a[0][2] = 10'd0; s4_a[0][2] = 10'd150;
      mx_a[1][0] = 1'b1; s2_a[1][0] = 10'd500; s3_a[1][0] = 10'd500; s4_a[1][0] = 10'd100;
      fire("R2 size code 3");
      chk(roi_word[7] == 1'b1 && roi_word[WW+7] == 1'b0, "R2 size 3 is 4x4",
          int'({roi_word[7], roi_word[WW+7]}), 2);
   endtask

   initial begin
      t_reset();
      t_mixed();
      t_no_max();
      t_overflow();
      t_saturate();
      t_hold();
      t_cfg_same_cycle();
      t_size3();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule